// File: doc/BRIEF.md
# ADSR Envelope Generator

This block produces the 15-bit amplitude envelope of one synthesizer voice. A key-on pulse restarts the envelope from silence in the attack phase. The level then rises to full scale, falls exponentially to a programmable sustain target, and stays in sustain until a key-off or forced-release pulse moves it into release. When release reaches zero the envelope stops and the active flag drops. Other logic multiplies the level with the voice samples.

Time advances only on `tick`, normally one pulse per output sample. On each tick the block either counts down a wait counter or applies one level step. The phase fields of the 32-bit configuration word set the step size and the wait length. A shift value trades step size against wait length around a shift of 11. An exponential flag makes rising steps slow down near full scale and makes falling steps scale with the current level.

Top module: `adsr_env`

## Requirements
- R1: After synchronous reset, `level_o` is 0, `phase_o` is 0 (stopped) and `active_o` is 0. Phase codes are 0 stopped, 1 attack, 2 decay, 3 sustain and 4 release.
- R2: A `key_on` pulse takes priority over every other input in the same cycle. On the next cycle `level_o` is 0, the phase is attack, `active_o` is 1 and the wait counter is cleared.
- R3: A `key_off` pulse without `key_on` or `force_rel` enters release and clears the wait counter, from any phase. The level is unchanged on that cycle, and a tick in the same cycle is ignored.
- R4: After a step whose wait length is W, the next W ticks only count down, and the step after them comes on tick W+1. Cycles without `tick` do not count.
- R5: Configuration fields: [3:0] sustain level, [7:4] decay shift, [9:8] attack step index, [14:10] attack shift, [15] attack exponential, [20:16] release shift, [21] release exponential, [23:22] sustain step index, [28:24] sustain shift, [30] sustain decreasing, [31] sustain exponential. An index i gives a base of 7-i when the level rises and -8+i when it falls. Decay and release always fall with base -8, and decay is always exponential. The applied step is base·2^max(11-shift,0) and the wait is 2^max(shift-11,0).
- R6: In an exponential falling phase, the step is multiplied by level/32768 with truncation toward zero. A result of 0 becomes -1.
- R7: In an exponential rising phase with the level above 0x6000, the adjustment depends on the shift. With a shift below 10 the step is divided by 4. With a shift of 11 or more the wait is multiplied by 4. With a shift of exactly 10 both adjustments apply.
- R8: After each step the level saturates to the range 0..0x7FFF.
- R9: Attack moves to decay when the level reaches 0x7FFF. Decay moves to sustain when the level is at or below the sustain target. Release moves to stopped when the level reaches 0. Sustain never leaves by itself.
- R10: The sustain target is (sustain level + 1)·0x800, capped at 0x7FFF.
- R11: A `force_rel` pulse without `key_on` enters release and clears the wait counter. Until the next key-on, release then runs linear with shift 0, whatever the release fields hold.
- R12: `active_o` clears on the same edge that enters the stopped phase. In the stopped phase, ticks change neither the level nor the phase.
- R13: A cycle with no `tick`, `key_on`, `key_off` or `force_rel` leaves the level, the phase and `active_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 32 | Envelope configuration word |
| key_on | input | 1 | Restart pulse |
| key_off | input | 1 | Release pulse |
| force_rel | input | 1 | Forced fast release pulse |
| tick | input | 1 | Per-sample advance strobe |
| level_o | output | 15 | Current envelope level |
| phase_o | output | 3 | Current phase code |
| active_o | output | 1 | Envelope running flag |

## Verification
All three outputs are registered. A pulse or tick presented before a rising edge shows its effect on the outputs right after that same edge, so every result is due one cycle after its stimulus. The bench drives inputs on the falling edge and advances its reference model for that cycle in the same step. It then compares all three outputs at the next falling edge, half a period after the edge that updated them. Waits of several ticks are checked cycle by cycle against the model's own countdown, so a step that comes one tick early or late is caught in the cycle where it happens.

// File: rtl/adsr_pkg.sv
package adsr_pkg;
    localparam int LVL_W   = 15;
    localparam int SHIFT_W = 5;
    localparam int STEP_W  = 18;
    localparam int WAIT_W  = 23;
    localparam int PIVOT   = 11;
    localparam logic [LVL_W-1:0] LVL_MAX  = '1;
    localparam logic [LVL_W-1:0] EXP_KNEE = 15'h6000;

    typedef enum logic [2:0] {
        PH_STOP = 3'd0,
        PH_ATK  = 3'd1,
        PH_DEC  = 3'd2,
        PH_SUS  = 3'd3,
        PH_REL  = 3'd4
    } phase_e;

    typedef struct packed {
        logic               expo;
        logic               falling;
        logic [SHIFT_W-1:0] shift;
        logic [1:0]         idx;
        logic               has_tgt;
        logic [LVL_W-1:0]   target;
    } rate_sel_t;

    // base step: rising 7..4, falling -8..-5
    function automatic logic signed [4:0] base_step(input logic [1:0] idx, input logic falling);
        if (falling) return $signed(5'(5'd24 + {3'b0, idx}));
        else         return $signed(5'(5'd7 - {3'b0, idx}));
    endfunction

    function automatic logic [LVL_W-1:0] sus_target(input logic [3:0] sl);
        logic [15:0] t;
        t = ({12'b0, sl} + 16'd1) << 11;
        return (t > 16'h7FFF) ? LVL_MAX : t[LVL_W-1:0];
    endfunction
endpackage

// File: rtl/adsr_rate.sv
module adsr_rate
    import adsr_pkg::*;
(
    input  logic [31:0]              cfg,
    input  phase_e                   phase,
    input  logic                     forced,
    input  logic [LVL_W-1:0]         level,
    output logic signed [STEP_W-1:0] step,
    output logic [WAIT_W-1:0]        wait_len,
    output logic                     falling,
    output logic                     has_tgt,
    output logic [LVL_W-1:0]         target
);
    rate_sel_t                       sel;
    logic signed [4:0]               base;
    logic [SHIFT_W-1:0]              nsh, wsh;
    logic signed [STEP_W-1:0]        lin;
    logic [WAIT_W-1:0]               wbase;
    logic signed [STEP_W+LVL_W:0]    prod, neg_mag;
    logic signed [STEP_W-1:0]        scaled;
    logic                            unused_bits;

    always_comb begin
        sel = '0;
        unique case (phase)
            PH_ATK: begin
                sel.expo = cfg[15]; sel.falling = 1'b0; sel.shift = cfg[14:10];
                sel.idx = cfg[9:8]; sel.has_tgt = 1'b1; sel.target = LVL_MAX;
            end
            PH_DEC: begin
                sel.expo = 1'b1; sel.falling = 1'b1; sel.shift = {1'b0, cfg[7:4]};
                sel.idx = 2'd0; sel.has_tgt = 1'b1; sel.target = sus_target(cfg[3:0]);
            end
            PH_SUS: begin
                sel.expo = cfg[31]; sel.falling = cfg[30]; sel.shift = cfg[28:24];
                sel.idx = cfg[23:22]; sel.has_tgt = 1'b0; sel.target = '0;
            end
            PH_REL: begin
                sel.expo = forced ? 1'b0 : cfg[21];
                sel.shift = forced ? '0 : cfg[20:16];
                sel.falling = 1'b1; sel.idx = 2'd0; sel.has_tgt = 1'b1; sel.target = '0;
            end
            default: sel = '0;
        endcase
    end

    always_comb begin
        base  = base_step(sel.idx, sel.falling);
        nsh   = (sel.shift < SHIFT_W'(PIVOT)) ? SHIFT_W'(PIVOT) - sel.shift : '0;
        wsh   = (sel.shift > SHIFT_W'(PIVOT)) ? sel.shift - SHIFT_W'(PIVOT) : '0;
        lin   = {{(STEP_W-5){base[4]}}, base} <<< nsh;
        wbase = WAIT_W'(1) << wsh;
        prod    = lin * $signed({1'b0, level});
        neg_mag = -prod;
        scaled  = -$signed(neg_mag[STEP_W+LVL_W-1:LVL_W]);
        step     = lin;
        wait_len = wbase;
        if (sel.expo && sel.falling) begin
            step = (scaled == '0) ? -STEP_W'(1) : scaled;
        end else if (sel.expo && level > EXP_KNEE) begin
            if (sel.shift < SHIFT_W'(10)) begin
                step = lin >>> 2;
            end else if (sel.shift >= SHIFT_W'(PIVOT)) begin
                wait_len = wbase << 2;
            end else begin
                step = lin >>> 2;
                wait_len = wbase << 2;
            end
        end
    end

    assign falling = sel.falling;
    assign has_tgt = sel.has_tgt;
    assign target  = sel.target;
    assign unused_bits = ^{cfg[29], neg_mag[STEP_W+LVL_W], neg_mag[LVL_W-1:0]};

    // R6: an exponential fall never yields a zero or rising step
    always_comb begin
        if (sel.expo && sel.falling && phase != PH_STOP)
            p_exp_fall_moves_r6: assert (step < 0);
    end
endmodule

// File: rtl/adsr_wait.sv
module adsr_wait
    import adsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              tick,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              idle
);
    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (tick && !idle)  cnt <= cnt - WAIT_W'(1);
    end

    assign idle = (cnt == '0);

    // R4: a waiting tick moves the count down by exactly one
    p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && !idle) |=> (cnt == $past(cnt) - WAIT_W'(1)));
    // R5: every loaded wait is at least one tick
    p_load_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));
endmodule

// File: rtl/adsr_env.sv
module adsr_env
    import adsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] cfg,
    input  logic        key_on,
    input  logic        key_off,
    input  logic        force_rel,
    input  logic        tick,
    output logic [14:0] level_o,
    output logic [2:0]  phase_o,
    output logic        active_o
);
    phase_e                   phase;
    logic [LVL_W-1:0]         level;
    logic                     active, forced;
    logic                     evt, idle, fire;
    logic signed [STEP_W-1:0] step;
    logic [WAIT_W-1:0]        wait_len;
    logic                     falling, has_tgt;
    logic [LVL_W-1:0]         target;
    logic signed [STEP_W:0]   sum;
    logic [LVL_W-1:0]         nxt_lvl;
    logic                     reached;

    assign evt  = key_on || key_off || force_rel;
    assign fire = tick && !evt && idle && (phase != PH_STOP);

    adsr_rate u_rate (
        .cfg(cfg), .phase(phase), .forced(forced), .level(level),
        .step(step), .wait_len(wait_len), .falling(falling),
        .has_tgt(has_tgt), .target(target)
    );

    adsr_wait u_wait (
        .clk(clk), .rst(rst), .clr(evt), .tick(tick),
        .load(fire), .load_val(wait_len), .idle(idle)
    );

    always_comb begin
        sum = $signed({{(STEP_W+1-LVL_W){1'b0}}, level}) + $signed({step[STEP_W-1], step});
        if (sum < 0)                                          nxt_lvl = '0;
        else if (sum > $signed({{(STEP_W+1-LVL_W){1'b0}}, LVL_MAX})) nxt_lvl = LVL_MAX;
        else                                                  nxt_lvl = sum[LVL_W-1:0];
        reached = has_tgt && (falling ? (nxt_lvl <= target) : (nxt_lvl >= target));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_STOP;
            level  <= '0;
            active <= 1'b0;
            forced <= 1'b0;
        end else if (key_on) begin
            phase  <= PH_ATK;
            level  <= '0;
            active <= 1'b1;
            forced <= 1'b0;
        end else if (force_rel) begin
            phase  <= PH_REL;
            forced <= 1'b1;
        end else if (key_off) begin
            phase  <= PH_REL;
        end else if (fire) begin
            level <= nxt_lvl;
            if (reached) begin
                unique case (phase)
                    PH_ATK: phase <= PH_DEC;
                    PH_DEC: phase <= PH_SUS;
                    PH_REL: begin
                        phase  <= PH_STOP;
                        active <= 1'b0;
                    end
                    default: phase <= phase;
                endcase
            end
        end
    end

    assign level_o  = level;
    assign phase_o  = phase;
    assign active_o = active;

    // R2: key-on restarts from silence in attack
    p_keyon_restart_r2: assert property (@(posedge clk) disable iff (rst)
        key_on |=> (level_o == '0 && phase_o == 3'd1 && active_o));
    // R3: key-off alone enters release with the level held
    p_keyoff_release_r3: assert property (@(posedge clk) disable iff (rst)
        (key_off && !key_on) |=> (phase_o == 3'd4 && $stable(level_o)));
    // R13: quiet cycles hold all state
    p_quiet_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !(tick || evt) |=> ($stable(level_o) && $stable(phase_o) && $stable(active_o)));
    // R12: stopped implies inactive
    p_stop_inactive_r12: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd0) |-> !active_o);
    // R9: attack never lowers the level
    p_attack_rises_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ATK && !evt) |=> (level_o >= $past(level_o)));
    // R9: sustain is only left through an event
    p_sustain_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SUS && !evt) |=> (phase_o == 3'd3));
endmodule

// File: tb/adsr_env_tb.sv
module adsr_env_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg = '0;
    logic        key_on = 1'b0, key_off = 1'b0, force_rel = 1'b0, tick = 1'b0;
    logic [14:0] level_o;
    logic [2:0]  phase_o;
    logic        active_o;

    int n_vec = 0, n_bad = 0;
    int m_lvl = 0, m_cnt = 0, m_ph = 0;
    bit m_act = 0, m_forced = 0;
    bit done = 0;

    always #10 clk = ~clk;

    adsr_env u_dut (
        .clk(clk), .rst(rst), .cfg(cfg), .key_on(key_on), .key_off(key_off),
        .force_rel(force_rel), .tick(tick), .level_o(level_o),
        .phase_o(phase_o), .active_o(active_o)
    );

    task automatic model_tick(input logic [31:0] c);
        int sh, base, st, w, tgt, nl;
        bit ex, dn, hast;
        ex = 0; dn = 0; hast = 0; sh = 0; base = 0; tgt = 0;
        case (m_ph)
            1: begin ex = c[15]; sh = int'(c[14:10]); base = 7 - int'(c[9:8]); tgt = 32767; hast = 1; end
            2: begin
                ex = 1; dn = 1; sh = int'(c[7:4]); base = -8; hast = 1;
                tgt = (int'(c[3:0]) + 1) * 2048; if (tgt > 32767) tgt = 32767;
            end
            3: begin
                ex = c[31]; dn = c[30]; sh = int'(c[28:24]);
                base = dn ? -8 + int'(c[23:22]) : 7 - int'(c[23:22]);
            end
            default: begin
                dn = 1; base = -8; hast = 1; tgt = 0;
                ex = m_forced ? 1'b0 : c[21]; sh = m_forced ? 0 : int'(c[20:16]);
            end
        endcase
        st = base * (1 << ((sh < 11) ? 11 - sh : 0));
        w  = 1 << ((sh > 11) ? sh - 11 : 0);
        if (ex && dn) begin
            st = (st * m_lvl) / 32768;
            if (st == 0) st = -1;
        end else if (ex && m_lvl > 24576) begin
            if (sh < 10) st = st / 4;
            else if (sh >= 11) w = w * 4;
            else begin st = st / 4; w = w * 4; end
        end
        m_cnt = w;
        nl = m_lvl + st;
        if (nl < 0) nl = 0;
        if (nl > 32767) nl = 32767;
        m_lvl = nl;
        if (hast && ((dn && m_lvl <= tgt) || (!dn && m_lvl >= tgt))) begin
            if (m_ph == 1) m_ph = 2;
            else if (m_ph == 2) m_ph = 3;
            else if (m_ph == 4) begin m_ph = 0; m_act = 0; end
        end
    endtask

    task automatic model_cycle(input bit kon, input bit koff, input bit frc, input bit tk);
        if (kon) begin m_lvl = 0; m_ph = 1; m_act = 1; m_cnt = 0; m_forced = 0; end
        else if (frc) begin m_ph = 4; m_cnt = 0; m_forced = 1; end
        else if (koff) begin m_ph = 4; m_cnt = 0; end
        else if (tk) begin
            if (m_cnt > 0) m_cnt = m_cnt - 1;
            else if (m_ph != 0) model_tick(cfg);
        end
    endtask

    task automatic compare(input string tag);
        n_vec++;
        if (level_o !== m_lvl[14:0] || phase_o !== m_ph[2:0] || active_o !== m_act) begin
            n_bad++;
            $display("FAIL %s: level/phase/active actual %h/%0d/%0b expected %h/%0d/%0b",
                     tag, level_o, phase_o, active_o, m_lvl[14:0], m_ph, m_act);
        end
    endtask

    // called at a falling edge; result compared at the next falling edge
    task automatic cyc(input bit kon, input bit koff, input bit frc, input bit tk, input string tag);
        key_on = kon; key_off = koff; force_rel = frc; tick = tk;
        model_cycle(kon, koff, frc, tk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, tag);
    endtask

    task automatic start(input logic [31:0] c, input string tag);
        cfg = c;
        cyc(1, 0, 0, 1, tag);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1");

        // R2, R9, R8: fast linear attack, exp decay to target 0x4000, linear rising sustain clamps
        start(32'h0000_0007, "R2");
        ticks(30, "R9");
        ticks(10, "R8");
        cyc(0, 1, 0, 1, "R3");
        ticks(8, "R12");
        ticks(5, "R12");
        // R13: quiet cycles
        start(32'h0000_0007, "R2");
        ticks(3, "R9");
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, "R13");
        // R2 priority over key_off and force_rel
        cyc(1, 1, 1, 1, "R2");
        // R4: attack shift 15, step 7 with wait 16
        start(32'h0000_3C00, "R4");
        for (int i = 0; i < 80; i++) cyc(0, 0, 0, (i % 3) != 0, "R4");
        cyc(0, 1, 0, 1, "R3");
        ticks(5, "R4");
        // R7: exponential attack at shifts 5, 10, 12
        start(32'h0000_9400, "R7");
        ticks(400, "R7");
        start(32'h0000_A800, "R7");
        ticks(200, "R7");
        start(32'h0000_B000, "R7");
        ticks(22000, "R7");
        // R6: exp decay shift 4, target 0x1800, exp release shift 3
        start(32'h0023_0042, "R6");
        ticks(400, "R6");
        cyc(0, 1, 0, 1, "R3");
        ticks(600, "R6");
        // R10: sustain level 15 target caps at 0x7FFF
        start(32'h0000_000F, "R10");
        ticks(10, "R10");
        // R11: slow release overridden by forced release
        start(32'h001F_0000, "R11");
        ticks(6, "R11");
        cyc(0, 0, 1, 1, "R11");
        ticks(10, "R11");
        start(32'h001F_0000, "R3");
        ticks(6, "R3");
        cyc(0, 1, 0, 0, "R3");
        ticks(50, "R3");
        // R8: linear falling sustain clamps at 0
        start(32'h4000_0000, "R8");
        ticks(40, "R8");
        // R5: random configurations and events
        for (int e = 0; e < 300; e++) begin
            logic [31:0] c;
            c = $urandom();
            if (e % 2 == 0) c = c & 32'hE3C3_83FF;
            start(c, "R5");
            for (int i = 0; i < 60; i++) begin
                int r;
                r = int'($urandom_range(0, 255));
                cyc(r == 0, r == 1 || r == 2, r == 3, r > 60, "R5");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule